// File: doc/BRIEF.md
# Instruction-List Stream DMA Sequencer

This block moves an incoming byte stream into memory buffers under the control of a list of instructions held in memory. Each instruction is two 32-bit words. The engine fetches the first word and then the second through a simple read port. It decodes the opcode and then does one of three things: it moves a counted run of stream bytes to a destination address, it waits for a coded stream event, or it loads a new fetch address. A list that ends with a jump back to its own start address runs without end.

Any valid instruction can update a 4-bit status value through its own clear and set masks. An instruction can also request an interrupt. Interrupt flags clear when software writes ones to them, and the interrupt pin follows only the flags that the mask register enables. Software writes a start address and then raises the enable bit. Dropping the enable bit makes the engine halt, and a running flag reports when it has halted.

Top module: `dma_list_seq`

## Requirements
- R1: After reset, `irq`, `mem_req`, `wr_valid`, `st_ready` and `sync_take` are low, and the control, status (index 3) and mask registers read zero.
- R2: The engine starts only when control bit 0 changes from 0 to 1 while the engine is halted. On that start it fetches word 0 from the start-address register (index 1) and then word 1 from that address plus 4. The next instruction follows at plus 8.
- R3: A WRITE (word 0 bits 31:28 = 0x1) takes exactly the byte count in bits 11:0 from the stream, in stream order. It presents them on the write port at word 1 + i and waits on `wr_ready`. A count of 0 moves no byte.
- R4: `wr_sol` marks the first byte of a WRITE whose bit 27 is set. `wr_eol` marks the last byte of a WRITE whose bit 26 is set.
- R5: Each WRITE, JUMP or SYNC updates the status value to (old AND NOT bits 23:20) OR bits 19:16, so a set bit wins over a clear bit. The value reads back in bits 31:28 of the status register.
- R6: A valid instruction with bit 24 set raises flag bit 0 of the status register.
- R7: A SYNC (opcode 0x8) stalls the engine until an event arrives on `sync_valid`. It takes that event with `sync_take`, and a code equal to bits 3:0 of word 0 lets the list continue.
- R8: When a SYNC sees a code that does not match, the result depends on bit 15. With bit 15 clear, the engine sets flag bit 2 and halts. With bit 15 set, the engine drops the event and keeps waiting.
- R9: Any opcode other than 0x1, 0x7 or 0x8 sets flag bit 1 and halts the engine without changing the status value.
- R10: A JUMP (opcode 0x7) makes word 1 the next fetch address.
- R11: Writing a 1 to a flag bit of the status register clears that bit, and writing a 0 leaves it unchanged. When a new event and the clear arrive in the same cycle, the new event wins.
- R12: `irq` is high exactly when some flag bit 2:0 is set and its matching bit is set in the mask register (index 4).
- R13: When control bit 0 is cleared, the engine halts at the end of the instruction in flight. If it is waiting on a SYNC, it halts at once. Status bit 8 (running) then reads 0, and no further fetch takes place.
- R14: The length register (index 2) stores the line count in bits 31:16, saturated at 255, and the bytes per line in bits 11:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Instruction read request |
| mem_addr | output | 32 | Instruction byte address |
| mem_ack | input | 1 | Read data valid for the current request |
| mem_rdata | input | 32 | Instruction word |
| st_valid | input | 1 | Stream byte valid |
| st_data | input | 8 | Stream byte |
| st_ready | output | 1 | Stream byte taken |
| sync_valid | input | 1 | Stream event present |
| sync_code | input | 4 | Stream event code |
| sync_take | output | 1 | Event consumed this cycle |
| wr_valid | output | 1 | Write byte valid |
| wr_addr | output | 32 | Write byte address |
| wr_data | output | 8 | Write byte |
| wr_sol | output | 1 | First byte of a line |
| wr_eol | output | 1 | Last byte of a line |
| wr_ready | input | 1 | Write sink accepts the byte |
| irq | output | 1 | Masked interrupt |

## Verification
A wrong fetch pointer shows up on `mem_addr` in the very next fetch cycle. A jump taken to the wrong target shows up as bytes arriving at the wrong destination. A wrong byte counter shows up within one line, as an extra or missing write byte, a misplaced `wr_eol`, or stream bytes left untaken. The status nibble and the flags can be read back in the cycle after the decode that changed them. A sequencing fault in the SYNC handling appears as a list that runs ahead without its event, or as a running bit that never drops.

// File: rtl/dls_pkg.sv
package dls_pkg;

  localparam logic [3:0] OP_WRITE = 4'h1;
  localparam logic [3:0] OP_JUMP  = 4'h7;
  localparam logic [3:0] OP_SYNC  = 4'h8;

  localparam int NFLAG     = 3;
  localparam int FLG_INSTR = 0;
  localparam int FLG_BADOP = 1;
  localparam int FLG_SYNC  = 2;

  localparam int RUN_BIT = 8;

  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] RA_CTRL  = 3'd0;
  localparam logic [REG_AW-1:0] RA_START = 3'd1;
  localparam logic [REG_AW-1:0] RA_LEN   = 3'd2;
  localparam logic [REG_AW-1:0] RA_ISTAT = 3'd3;
  localparam logic [REG_AW-1:0] RA_IMASK = 3'd4;
  localparam logic [REG_AW-1:0] RA_PC    = 3'd5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH0,
    ST_FETCH1,
    ST_MOVE,
    ST_WAIT
  } eng_state_t;

  function automatic logic [3:0] op_of(input logic [31:0] w);
    return w[31:28];
  endfunction

  function automatic logic op_known(input logic [3:0] op);
    return (op == OP_WRITE) || (op == OP_JUMP) || (op == OP_SYNC);
  endfunction

  function automatic logic [3:0] status_apply(input logic [3:0] cur, input logic [31:0] w);
    return (cur & ~w[23:20]) | w[19:16];
  endfunction

  function automatic logic [15:0] clip_lines(input logic [15:0] req, input int unsigned lim);
    return (32'(req) > lim) ? 16'(lim) : req;
  endfunction

endpackage

// File: rtl/dls_regs.sv
module dls_regs
  import dls_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 12,
  parameter int MAX_LINES = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              ctrl_en,
  output logic [ADDR_W-1:0] start_addr,
  input  logic [NFLAG-1:0]  flag_set,
  input  logic              running,
  input  logic [3:0]        status,
  input  logic [ADDR_W-1:0] pc,
  output logic              irq,
  output logic [NFLAG-1:0]  flags,
  output logic [NFLAG-1:0]  mask,
  output logic [NFLAG-1:0]  w1c,
  output logic [15:0]       len_lines
);

  logic [CNT_W-1:0] len_bytes;

  assign w1c = (reg_we && reg_addr == RA_ISTAT) ? reg_wdata[NFLAG-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_en    <= 1'b0;
      start_addr <= '0;
      len_lines  <= '0;
      len_bytes  <= '0;
      flags      <= '0;
      mask       <= '0;
    end else begin
      flags <= (flags & ~w1c) | flag_set;
      if (reg_we) begin
        case (reg_addr)
          RA_CTRL:  ctrl_en    <= reg_wdata[0];
          RA_START: start_addr <= reg_wdata[ADDR_W-1:0];
          RA_LEN: begin
            len_lines <= clip_lines(reg_wdata[31:16], MAX_LINES);
            len_bytes <= reg_wdata[CNT_W-1:0];
          end
          RA_IMASK: mask <= reg_wdata[NFLAG-1:0];
          default: ;
        endcase
      end
    end
  end

  assign irq = |(flags & mask);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL:  reg_rdata[0] = ctrl_en;
      RA_START: reg_rdata = 32'(start_addr);
      RA_LEN:   reg_rdata = {len_lines, 16'(len_bytes)};
      RA_ISTAT: begin
        reg_rdata[31:28]      = status;
        reg_rdata[RUN_BIT]    = running;
        reg_rdata[NFLAG-1:0]  = flags;
      end
      RA_IMASK: reg_rdata[NFLAG-1:0] = mask;
      RA_PC:    reg_rdata = 32'(pc);
      default:  reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/dls_mover.sv
module dls_mover #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [CNT_W-1:0]  go_cnt,
  input  logic [ADDR_W-1:0] go_base,
  input  logic              go_sol,
  input  logic              go_eol,
  input  logic              st_valid,
  input  logic [7:0]        st_data,
  output logic              st_ready,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_sol,
  output logic              wr_eol,
  output logic              done
);

  logic              active;
  logic [ADDR_W-1:0] base;
  logic [CNT_W-1:0]  idx;
  logic [CNT_W-1:0]  last_idx;
  logic              sol_f;
  logic              eol_f;
  logic              is_last;
  logic              xfer;

  function automatic logic [ADDR_W-1:0] byte_addr(input logic [ADDR_W-1:0] b,
                                                  input logic [CNT_W-1:0] i);
    return b + ADDR_W'(i);
  endfunction

  assign is_last  = (idx == last_idx);
  assign wr_valid = active && st_valid;
  assign st_ready = active && wr_ready;
  assign xfer     = wr_valid && wr_ready;
  assign done     = xfer && is_last;
  assign wr_addr  = byte_addr(base, idx);
  assign wr_data  = st_data;
  assign wr_sol   = wr_valid && sol_f && (idx == '0);
  assign wr_eol   = wr_valid && eol_f && is_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      base     <= '0;
      idx      <= '0;
      last_idx <= '0;
      sol_f    <= 1'b0;
      eol_f    <= 1'b0;
    end else if (go) begin
      active   <= 1'b1;
      base     <= go_base;
      idx      <= '0;
      last_idx <= go_cnt - CNT_W'(1);
      sol_f    <= go_sol;
      eol_f    <= go_eol;
    end else if (xfer) begin
      if (is_last) active <= 1'b0;
      else         idx    <= idx + CNT_W'(1);
    end
  end

endmodule

// File: rtl/dls_engine.sv
module dls_engine
  import dls_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_en,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  input  logic              sync_valid,
  input  logic [3:0]        sync_code,
  output logic              sync_take,
  output logic              mv_go,
  output logic [CNT_W-1:0]  mv_cnt,
  output logic [ADDR_W-1:0] mv_base,
  output logic              mv_sol,
  output logic              mv_eol,
  input  logic              mv_done,
  output logic              running,
  output logic [3:0]        status,
  output logic [ADDR_W-1:0] pc,
  output logic              ev_decode,
  output logic              ev_instr_irq,
  output logic              ev_err_op,
  output logic              ev_err_sync
);

  eng_state_t        state, state_n;
  logic [ADDR_W-1:0] pc_n;
  logic [31:0]       w0, w0_n;
  logic [3:0]        status_n;
  logic              en_q;
  logic [3:0]        op;
  eng_state_t        boundary;

  assign running = (state != ST_IDLE);
  assign mv_cnt  = w0[CNT_W-1:0];
  assign mv_base = mem_rdata[ADDR_W-1:0];
  assign mv_sol  = w0[27];
  assign mv_eol  = w0[26];

  always_comb begin
    state_n      = state;
    pc_n         = pc;
    w0_n         = w0;
    status_n     = status;
    mem_req      = 1'b0;
    mem_addr     = pc;
    sync_take    = 1'b0;
    mv_go        = 1'b0;
    ev_decode    = 1'b0;
    ev_instr_irq = 1'b0;
    ev_err_op    = 1'b0;
    ev_err_sync  = 1'b0;
    op           = op_of(w0);
    boundary     = ctrl_en ? ST_FETCH0 : ST_IDLE;
    case (state)
      ST_IDLE: begin
        if (ctrl_en && !en_q) begin
          pc_n    = start_addr;
          state_n = ST_FETCH0;
        end
      end
      ST_FETCH0: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          w0_n    = mem_rdata;
          state_n = ST_FETCH1;
        end
      end
      ST_FETCH1: begin
        mem_req  = 1'b1;
        mem_addr = pc + ADDR_W'(4);
        if (mem_ack) begin
          ev_decode = 1'b1;
          pc_n      = pc + ADDR_W'(8);
          if (op_known(op)) begin
            status_n     = status_apply(status, w0);
            ev_instr_irq = w0[24];
          end
          case (op)
            OP_WRITE: begin
              if (w0[CNT_W-1:0] != '0) begin
                mv_go   = 1'b1;
                state_n = ST_MOVE;
              end else begin
                state_n = boundary;
              end
            end
            OP_JUMP: begin
              pc_n    = mem_rdata[ADDR_W-1:0];
              state_n = boundary;
            end
            OP_SYNC: state_n = ST_WAIT;
            default: begin
              ev_err_op = 1'b1;
              state_n   = ST_IDLE;
            end
          endcase
        end
      end
      ST_MOVE: begin
        if (mv_done) state_n = boundary;
      end
      ST_WAIT: begin
        if (!ctrl_en) begin
          state_n = ST_IDLE;
        end else if (sync_valid) begin
          sync_take = 1'b1;
          if (sync_code == w0[3:0]) begin
            state_n = boundary;
          end else if (!w0[15]) begin
            ev_err_sync = 1'b1;
            state_n     = ST_IDLE;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      pc     <= '0;
      w0     <= '0;
      status <= '0;
      en_q   <= 1'b0;
    end else begin
      state  <= state_n;
      pc     <= pc_n;
      w0     <= w0_n;
      status <= status_n;
      en_q   <= ctrl_en;
    end
  end

endmodule

// File: rtl/dma_list_seq.sv
module dma_list_seq
  import dls_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 12,
  parameter int MAX_LINES = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  input  logic              st_valid,
  input  logic [7:0]        st_data,
  output logic              st_ready,
  input  logic              sync_valid,
  input  logic [3:0]        sync_code,
  output logic              sync_take,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_sol,
  output logic              wr_eol,
  input  logic              wr_ready,
  output logic              irq
);

  logic              ctrl_en;
  logic [ADDR_W-1:0] start_addr;
  logic              running;
  logic [3:0]        status;
  logic [ADDR_W-1:0] pc;
  logic [NFLAG-1:0]  flags;
  logic [NFLAG-1:0]  mask;
  logic [NFLAG-1:0]  w1c;
  logic [NFLAG-1:0]  flag_set;
  logic [15:0]       len_lines;
  logic              mv_go;
  logic [CNT_W-1:0]  mv_cnt;
  logic [ADDR_W-1:0] mv_base;
  logic              mv_sol;
  logic              mv_eol;
  logic              mv_done;
  logic              ev_decode;
  logic              ev_instr_irq;
  logic              ev_err_op;
  logic              ev_err_sync;

  always_comb begin
    flag_set            = '0;
    flag_set[FLG_INSTR] = ev_instr_irq;
    flag_set[FLG_BADOP] = ev_err_op;
    flag_set[FLG_SYNC]  = ev_err_sync;
  end

  dls_regs #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MAX_LINES(MAX_LINES)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ctrl_en(ctrl_en), .start_addr(start_addr),
    .flag_set(flag_set), .running(running), .status(status), .pc(pc),
    .irq(irq), .flags(flags), .mask(mask), .w1c(w1c), .len_lines(len_lines)
  );

  dls_engine #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_engine (
    .clk(clk), .rst_n(rst_n),
    .ctrl_en(ctrl_en), .start_addr(start_addr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .sync_valid(sync_valid), .sync_code(sync_code), .sync_take(sync_take),
    .mv_go(mv_go), .mv_cnt(mv_cnt), .mv_base(mv_base), .mv_sol(mv_sol), .mv_eol(mv_eol),
    .mv_done(mv_done),
    .running(running), .status(status), .pc(pc),
    .ev_decode(ev_decode), .ev_instr_irq(ev_instr_irq),
    .ev_err_op(ev_err_op), .ev_err_sync(ev_err_sync)
  );

  dls_mover #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_mover (
    .clk(clk), .rst_n(rst_n),
    .go(mv_go), .go_cnt(mv_cnt), .go_base(mv_base), .go_sol(mv_sol), .go_eol(mv_eol),
    .st_valid(st_valid), .st_data(st_data), .st_ready(st_ready),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_sol(wr_sol), .wr_eol(wr_eol), .done(mv_done)
  );

endmodule

// File: rtl/dls_chk.sv
module dls_chk #(
  parameter int ADDR_W    = 32,
  parameter int MAX_LINES = 255
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              st_ready,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              irq,
  input logic              running,
  input logic [3:0]        status,
  input logic [2:0]        flags,
  input logic [2:0]        mask,
  input logic [2:0]        w1c,
  input logic              ev_decode,
  input logic              ev_instr_irq,
  input logic              ev_err_op,
  input logic              ev_err_sync,
  input logic              mv_done,
  input logic [15:0]       len_lines
);

  // R2
  fetch_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && !ev_decode) |=> (mem_req && mem_addr == $past(mem_addr) + ADDR_W'(4)));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !mv_done) |=> (wr_addr == $past(wr_addr) + ADDR_W'(1)));

  // R5
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_decode |=> $stable(status));

  // R6
  instr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_instr_irq |=> flags[0]);

  // R8
  sync_err_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err_sync |=> (!running && flags[2]));

  // R9
  bad_op_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err_op |=> (!running && flags[1]));

  // R11
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (w1c[0] && !ev_instr_irq) |=> !flags[0]);

  // R12
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_instr_irq && mask[0]) |=> (irq || !mask[0]));

  // R13
  halted_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!mem_req && !st_ready));

  // R14
  line_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(len_lines) <= MAX_LINES);

endmodule

bind dma_list_seq dls_chk #(.ADDR_W(ADDR_W), .MAX_LINES(MAX_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .st_ready(st_ready), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
  .irq(irq), .running(running), .status(status),
  .flags(flags), .mask(mask), .w1c(w1c),
  .ev_decode(ev_decode), .ev_instr_irq(ev_instr_irq),
  .ev_err_op(ev_err_op), .ev_err_sync(ev_err_sync),
  .mv_done(mv_done), .len_lines(len_lines)
);

// File: tb/dma_list_seq_tb.sv
`timescale 1ns/1ps
module dma_list_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack;
  logic [31:0] mem_rdata;
  logic        st_valid = 1'b0;
  logic [7:0]  st_data = '0;
  logic        st_ready;
  logic        sync_valid = 1'b0;
  logic [3:0]  sync_code = '0;
  logic        sync_take;
  logic        wr_valid;
  logic [31:0] wr_addr;
  logic [7:0]  wr_data;
  logic        wr_sol;
  logic        wr_eol;
  logic        wr_ready = 1'b1;
  logic        irq;

  int checks = 0;
  int failures = 0;

  logic [31:0] mem [0:63];
  assign mem_ack   = mem_req;
  assign mem_rdata = mem[mem_addr[7:2]];

  logic [7:0]  sbytes [0:63];
  int          slen = 0, sptr = 0;
  logic        st_took = 1'b0, sy_took = 1'b0, sy_pend = 1'b0;
  logic [3:0]  sy_code = '0;
  logic        throttle = 1'b0;
  int          cyc_n = 0;
  logic [31:0] cap_addr [0:63];
  logic [7:0]  cap_data [0:63];
  logic        cap_sol  [0:63];
  logic        cap_eol  [0:63];
  int          ncap = 0;

  always #2 clk = ~clk;

  dma_list_seq u_dut (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .st_valid(st_valid), .st_data(st_data), .st_ready(st_ready),
    .sync_valid(sync_valid), .sync_code(sync_code), .sync_take(sync_take),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_sol(wr_sol), .wr_eol(wr_eol), .wr_ready(wr_ready), .irq(irq)
  );

  // stimulus drive and observation, away from the active edge
  always @(negedge clk) begin
    if (st_took) sptr = sptr + 1;
    if (sy_took) sy_pend = 1'b0;
    st_valid   = (sptr < slen);
    st_data    = sbytes[sptr[5:0]];
    sync_valid = sy_pend;
    sync_code  = sy_code;
    cyc_n      = cyc_n + 1;
    wr_ready   = !(throttle && (cyc_n % 3 == 0));
    #1;
    st_took = st_valid && st_ready;
    sy_took = sync_valid && sync_take;
    if (wr_valid && wr_ready && ncap < 64) begin
      cap_addr[ncap] = wr_addr;
      cap_data[ncap] = wr_data;
      cap_sol[ncap]  = wr_sol;
      cap_eol[ncap]  = wr_eol;
      ncap = ncap + 1;
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] iw_write(input bit sol, input bit eol, input bit ir,
                                           input logic [3:0] set, input logic [3:0] clr,
                                           input logic [11:0] cnt);
    return {4'h1, sol, eol, 1'b0, ir, clr, set, 4'h0, cnt};
  endfunction

  function automatic logic [31:0] iw_sync(input bit rs, input logic [3:0] code);
    return {4'h8, 12'h000, rs, 11'h000, code};
  endfunction

  function automatic logic [31:0] iw_jump();
    return {4'h7, 28'h0};
  endfunction

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic do_reset();
    @(posedge clk);
    rst_n = 1'b0;
    slen = 0; sptr = 0; st_took = 1'b0; sy_took = 1'b0; sy_pend = 1'b0;
    ncap = 0; throttle = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic give_sync(input logic [3:0] code);
    @(posedge clk);
    sy_code = code;
    sy_pend = 1'b1;
    for (int i = 0; i < 60 && sy_pend; i++) @(posedge clk);
    chk("R7 event taken", {31'b0, sy_pend}, 32'h0);
  endtask

  task automatic wait_caps(input int n);
    for (int i = 0; i < 300 && ncap < n; i++) @(negedge clk);
    chk("R3 byte count reached", ncap, n);
  endtask

  task automatic check_cap(input int i, input logic [31:0] a, input logic [7:0] d,
                           input bit s, input bit e);
    chk("R3 write address", cap_addr[i], a);
    chk("R3 write data", {24'b0, cap_data[i]}, {24'b0, d});
    chk("R4 start-of-line mark", {31'b0, cap_sol[i]}, {31'b0, s});
    chk("R4 end-of-line mark", {31'b0, cap_eol[i]}, {31'b0, e});
  endtask

  // R1
  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    @(negedge clk); #1;
    chk("R1 irq low", {31'b0, irq}, 32'h0);
    chk("R1 no fetch", {31'b0, mem_req}, 32'h0);
    chk("R1 no write", {31'b0, wr_valid}, 32'h0);
    chk("R1 stream idle", {31'b0, st_ready}, 32'h0);
    chk("R1 no event take", {31'b0, sync_take}, 32'h0);
    reg_read(3'd0, v); chk("R1 control", v, 32'h0);
    reg_read(3'd3, v); chk("R1 status", v, 32'h0);
    reg_read(3'd4, v); chk("R1 mask", v, 32'h0);
  endtask

  // R2 R3 R4 R5 R6 R7 R10 R11 R12 R13
  task automatic t_loop();
    logic [31:0] v;
    do_reset();
    mem[0] = iw_sync(1'b0, 4'h6);                      mem[1] = 32'h0;
    mem[2] = iw_write(1, 1, 1, 4'h3, 4'hC, 12'd4);     mem[3] = 32'h1000;
    mem[4] = iw_write(0, 1, 0, 4'h0, 4'h0, 12'd3);     mem[5] = 32'h2000;
    mem[6] = iw_sync(1'b0, 4'hC);                      mem[7] = 32'h0;
    mem[8] = iw_jump();                                mem[9] = 32'h0;
    for (int i = 0; i < 14; i++) sbytes[i] = 8'(8'h10 + i);
    slen = 12;
    reg_write(3'd4, 32'h1);
    reg_write(3'd1, 32'h0);
    reg_write(3'd0, 32'h1);
    repeat (6) @(negedge clk);
    chk("R7 no bytes before event", ncap, 0);
    give_sync(4'h6);
    wait_caps(7);
    for (int i = 0; i < 4; i++) check_cap(i, 32'h1000 + i, 8'(8'h10 + i), i == 0, i == 3);
    for (int i = 4; i < 7; i++) check_cap(i, 32'h2000 + i - 4, 8'(8'h10 + i), 1'b0, i == 6);
    repeat (4) @(negedge clk);
    reg_read(3'd3, v);
    chk("R5 status set", {28'b0, v[31:28]}, 32'h3);
    chk("R6 instruction flag", {31'b0, v[0]}, 32'h1);
    chk("R13 running", {31'b0, v[8]}, 32'h1);
    chk("R12 irq enabled", {31'b0, irq}, 32'h1);
    reg_write(3'd3, 32'h1);
    reg_read(3'd3, v);
    chk("R11 flag cleared", {31'b0, v[0]}, 32'h0);
    chk("R12 irq dropped", {31'b0, irq}, 32'h0);
    give_sync(4'hC);
    give_sync(4'h6);
    wait_caps(12);
    for (int i = 7; i < 11; i++) check_cap(i, 32'h1000 + i - 7, 8'(8'h10 + i), i == 7, i == 10);
    check_cap(11, 32'h2000, 8'h1B, 1'b0, 1'b0);
    reg_read(3'd3, v);
    chk("R10 loop re-raised flag", {31'b0, v[0]}, 32'h1);
    @(posedge clk); slen = 14;
    wait_caps(14);
    check_cap(13, 32'h2002, 8'h1D, 1'b0, 1'b1);
    repeat (6) @(negedge clk);
    chk("R3 stream fully used", sptr, 14);
    reg_write(3'd0, 32'h0);
    repeat (3) @(negedge clk);
    reg_read(3'd3, v);
    chk("R13 halted", {31'b0, v[8]}, 32'h0);
  endtask

  // R3 R5 R13
  task automatic t_status();
    logic [31:0] v;
    do_reset();
    mem[16] = iw_write(0, 0, 0, 4'hA, 4'h5, 12'd0);   mem[17] = 32'h500;
    mem[18] = iw_write(0, 0, 0, 4'h0, 4'h2, 12'd0);   mem[19] = 32'h600;
    mem[20] = iw_write(0, 0, 0, 4'h1, 4'h1, 12'd0);   mem[21] = 32'h700;
    mem[22] = iw_sync(1'b0, 4'h6);                    mem[23] = 32'h0;
    for (int i = 0; i < 4; i++) sbytes[i] = 8'hEE;
    slen = 4;
    reg_write(3'd1, 32'h40);
    reg_write(3'd0, 32'h1);
    repeat (15) @(negedge clk);
    reg_read(3'd3, v);
    chk("R5 set wins over clear", {28'b0, v[31:28]}, 32'h9);
    chk("R3 zero count moves nothing", ncap, 0);
    chk("R3 zero count takes no stream", sptr, 0);
    reg_write(3'd0, 32'h0);
    repeat (2) @(negedge clk);
    reg_read(3'd3, v);
    chk("R13 stop during event wait", {31'b0, v[8]}, 32'h0);
    repeat (5) @(negedge clk);
    chk("R13 no further fetch", {31'b0, mem_req}, 32'h0);
  endtask

  // R9 R11 R12
  task automatic t_badop();
    logic [31:0] v;
    do_reset();
    mem[32] = {4'h3, 28'h0F0_0000}; mem[33] = 32'h0;
    reg_write(3'd4, 32'h2);
    reg_write(3'd1, 32'h80);
    reg_write(3'd0, 32'h1);
    repeat (6) @(negedge clk);
    reg_read(3'd3, v);
    chk("R9 bad opcode flag", {31'b0, v[1]}, 32'h1);
    chk("R9 halted", {31'b0, v[8]}, 32'h0);
    chk("R9 status untouched", {28'b0, v[31:28]}, 32'h0);
    chk("R12 irq for enabled flag", {31'b0, irq}, 32'h1);
    reg_write(3'd3, 32'h0);
    reg_read(3'd3, v);
    chk("R11 zero write keeps flag", {31'b0, v[1]}, 32'h1);
    reg_write(3'd3, 32'h2);
    reg_read(3'd3, v);
    chk("R11 one write clears flag", {31'b0, v[1]}, 32'h0);
    chk("R12 irq released", {31'b0, irq}, 32'h0);
  endtask

  // R8 R12
  task automatic t_sync_err();
    logic [31:0] v;
    do_reset();
    mem[40] = iw_sync(1'b1, 4'h6); mem[41] = 32'h0;
    mem[42] = iw_sync(1'b0, 4'hC); mem[43] = 32'h0;
    reg_write(3'd1, 32'hA0);
    reg_write(3'd0, 32'h1);
    give_sync(4'h3);
    repeat (3) @(negedge clk);
    reg_read(3'd3, v);
    chk("R8 resync drops mismatch", {31'b0, v[8]}, 32'h1);
    chk("R8 no error on resync", {31'b0, v[2]}, 32'h0);
    give_sync(4'h6);
    give_sync(4'h6);
    repeat (3) @(negedge clk);
    reg_read(3'd3, v);
    chk("R8 mismatch flag", {31'b0, v[2]}, 32'h1);
    chk("R8 mismatch halts", {31'b0, v[8]}, 32'h0);
    chk("R12 masked flag keeps irq low", {31'b0, irq}, 32'h0);
  endtask

  // R3 R4 (write-side backpressure)
  task automatic t_backpressure();
    do_reset();
    mem[48] = iw_write(1, 1, 0, 4'h0, 4'h0, 12'd5); mem[49] = 32'h3000;
    mem[50] = iw_sync(1'b0, 4'h6);                  mem[51] = 32'h0;
    for (int i = 0; i < 8; i++) sbytes[i] = 8'(8'h40 + i);
    slen = 8;
    throttle = 1'b1;
    reg_write(3'd1, 32'hC0);
    reg_write(3'd0, 32'h1);
    wait_caps(5);
    for (int i = 0; i < 5; i++) check_cap(i, 32'h3000 + i, 8'(8'h40 + i), i == 0, i == 4);
    repeat (8) @(negedge clk);
    chk("R3 exact byte count under backpressure", sptr, 5);
    chk("R3 no extra writes", ncap, 5);
    reg_write(3'd0, 32'h0);
  endtask

  // R14
  task automatic t_len();
    logic [31:0] v;
    do_reset();
    reg_write(3'd2, 32'h0300_0100);
    reg_read(3'd2, v);
    chk("R14 line count saturates", v, 32'h00FF_0100);
    reg_write(3'd2, 32'h0010_0800);
    reg_read(3'd2, v);
    chk("R14 in-range value kept", v, 32'h0010_0800);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i] = 32'h0;
      sbytes[i] = 8'h0;
    end
    t_reset();
    t_loop();
    t_status();
    t_badop();
    t_sync_err();
    t_backpressure();
    t_len();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule